// File: doc/BRIEF.md
# Bidirectional Prescaled Timer Counter

This block is a timer counter core driven by a register-style control port. A single write strobe loads a control word that carries a halt bit, a stop bit, a clear-counter command, a bidirectional-mode bit and a prescale value. The read outputs report the stored bits, the current direction flag and the count. The counter moves one step on each prescaled tick. The tick fires once every prescale+1 clock cycles while the counter is running.

There are two non-running states. Halt is set by reset and only a software write can release it. While halted, no tick occurs and incoming events are ignored. Stop also freezes the count, but events are still watched. An event that matches the start mask clears stop, and counting resumes without software.

A limit input is sampled on each tick. In unidirectional mode, a limit makes the counter restart at zero. In bidirectional mode, a limit reverses the direction. The direction flag also drops when a down count reaches zero. A one-cycle pulse marks every limit that is acted on.

Top module: `updown_timer`

## Requirements
- R1: After reset, halt reads 1, while stop, bidir, down, the prescale value and the count all read 0.
- R2: While neither halted nor stopped, the count changes once every prescale+1 clock cycles. Counting upward without a limit, it wraps from its maximum value to 0.
- R3: A control write with the clear bit at 1 sets the count, the direction flag and the prescale divider to 0. The clear bit always reads back as 0.
- R4: While halt is 1, the count holds, no limit takes effect, and a matching start event does not change stop.
- R5: A write with halt at 1 leaves stop reading 0, even when the same write sets stop to 1.
- R6: Only a control write clears halt. One write can clear halt and set stop together, which leaves the counter stopped.
- R7: While stopped and not halted, the count holds. In a cycle where evt_in AND start_mask is nonzero, stop reads 0 from the next cycle, and counting resumes one cycle after that. An event outside the mask has no effect.
- R8: In unidirectional mode (bidir 0), a tick with limit_in at 1 makes the count 0, and the down flag stays 0.
- R9: In bidirectional mode, a tick with limit_in at 1 while counting up sets down to 1 and decrements the count on that tick.
- R10: In bidirectional mode, a tick with limit_in at 1 while counting down clears down and increments the count on that tick.
- R11: While down is 1, the count decrements on each tick. The tick that brings it to 0 also clears down, so the following ticks count up.
- R12: limit_hit is 1 exactly in the cycles where a tick occurs with limit_in at 1. It stays 0 on cycles without a tick, including when stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctrl | input | 1 | Control write strobe |
| wd_halt | input | 1 | Halt value to write |
| wd_stop | input | 1 | Stop value to write |
| wd_clear | input | 1 | Clear-counter command, acted on when 1 |
| wd_bidir | input | 1 | Bidirectional mode value to write |
| wd_pre | input | PRE_W | Prescale value to write |
| limit_in | input | 1 | Limit condition, sampled on ticks |
| evt_in | input | EVT_W | Incoming event lines |
| start_mask | input | EVT_W | Events that may restart a stopped counter |
| rd_halt | output | 1 | Stored halt bit |
| rd_stop | output | 1 | Stored stop bit |
| rd_clear | output | 1 | Clear bit read-back, always 0 |
| rd_bidir | output | 1 | Stored bidirectional mode bit |
| rd_down | output | 1 | Direction flag, 1 while counting down |
| rd_pre | output | PRE_W | Stored prescale value |
| count | output | CNT_W | Current counter value |
| tick | output | 1 | Prescaled tick in this cycle |
| limit_hit | output | 1 | A limit is acted on in this cycle |

## Verification
The bench builds the block with CNT_W=8, PRE_W=4 and EVT_W=4. The 8-bit count makes the wrap from 255 to 0 reachable in a few hundred cycles. The 4-bit prescale field lets the vector table include the largest divide ratio of 16. Four event lines allow the bench to apply one event outside the mask and one inside it, and to show that the start logic tells them apart.

// File: rtl/updown_timer.sv
module updown_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wd_halt,
  input  logic             wd_stop,
  input  logic             wd_clear,
  input  logic             wd_bidir,
  input  logic [PRE_W-1:0] wd_pre,
  input  logic             limit_in,
  input  logic [EVT_W-1:0] evt_in,
  input  logic [EVT_W-1:0] start_mask,
  output logic             rd_halt,
  output logic             rd_stop,
  output logic             rd_clear,
  output logic             rd_bidir,
  output logic             rd_down,
  output logic [PRE_W-1:0] rd_pre,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             limit_hit
);

  logic             halt_q, stop_q, bidir_q, down_q;
  logic [PRE_W-1:0] pre_q, div_q;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_dec;
  logic             down_n, running, start_evt, clr_cmd;

  assign clr_cmd   = wr_ctrl & wd_clear;
  assign running   = ~halt_q & ~stop_q;
  assign tick      = running & (div_q >= pre_q);
  assign start_evt = ~halt_q & stop_q & (|(evt_in & start_mask));
  assign limit_hit = tick & limit_in;
  assign cnt_dec   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b1;
      stop_q  <= 1'b0;
      bidir_q <= 1'b0;
      pre_q   <= '0;
    end else if (wr_ctrl) begin
      halt_q  <= wd_halt;
      stop_q  <= wd_stop & ~wd_halt;
      bidir_q <= wd_bidir;
      pre_q   <= wd_pre;
    end else if (start_evt) begin
      stop_q  <= 1'b0;
    end
  end

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    if (limit_in) begin
      if (!bidir_q) begin
        cnt_n  = '0;
        down_n = 1'b0;
      end else if (!down_q) begin
        cnt_n  = cnt_dec;
        down_n = 1'b1;
      end else begin
        cnt_n  = cnt_q + 1'b1;
        down_n = 1'b0;
      end
    end else if (down_q) begin
      cnt_n = cnt_dec;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
    if (down_n && cnt_n == '0) down_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (clr_cmd) begin
      div_q  <= '0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (running) begin
      if (tick) begin
        div_q  <= '0;
        cnt_q  <= cnt_n;
        down_q <= down_n;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign rd_halt  = halt_q;
  assign rd_stop  = stop_q;
  assign rd_clear = 1'b0;
  assign rd_bidir = bidir_q;
  assign rd_down  = down_q;
  assign rd_pre   = pre_q;
  assign count    = cnt_q;

  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !clr_cmd) |=> $stable(cnt_q));
  p_halt_kills_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !stop_q);
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_ctrl) |=> halt_q);
  p_start_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !halt_q && (|(evt_in & start_mask)) && !wr_ctrl) |=> !stop_q);
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clr_cmd) |=> $stable(cnt_q));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (cnt_q == '0 && !down_q));
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_hit && !bidir_q && !clr_cmd) |=> (cnt_q == '0 && !down_q));
  p_down_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    down_q |-> cnt_q != '0);
  p_hit_needs_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |-> (running && limit_in));

endmodule

// File: tb/sim_updown_timer.sv
module sim_updown_timer;
  logic       clk = 0, rst_n = 0;
  logic       wr_ctrl = 0, wd_halt = 0, wd_stop = 0, wd_clear = 0, wd_bidir = 0;
  logic [3:0] wd_pre = 0;
  logic       limit_in = 0;
  logic [3:0] evt_in = 0, start_mask = 0;
  logic       rd_halt, rd_stop, rd_clear, rd_bidir, rd_down, tick, limit_hit;
  logic [3:0] rd_pre;
  logic [7:0] count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  updown_timer #(.CNT_W(8), .PRE_W(4), .EVT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wd_halt(wd_halt), .wd_stop(wd_stop),
    .wd_clear(wd_clear), .wd_bidir(wd_bidir), .wd_pre(wd_pre), .limit_in(limit_in),
    .evt_in(evt_in), .start_mask(start_mask), .rd_halt(rd_halt), .rd_stop(rd_stop),
    .rd_clear(rd_clear), .rd_bidir(rd_bidir), .rd_down(rd_down), .rd_pre(rd_pre),
    .count(count), .tick(tick), .limit_hit(limit_hit));

  localparam int NV = 6;
  localparam int VEC [NV][3] = '{'{0, 5, 5}, '{1, 7, 3}, '{2, 9, 3},
                                 '{3, 10, 2}, '{7, 16, 2}, '{15, 33, 2}};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(bit h, bit s, bit c, bit b, int p);
    wr_ctrl = 1; wd_halt = h; wd_stop = s; wd_clear = c; wd_bidir = b; wd_pre = 4'(p);
    @(negedge clk);
    wr_ctrl = 0; wd_clear = 0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int hits;
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 halt", rd_halt, 1);
    chk("R1 stop", rd_stop, 0);
    chk("R1 bidir", rd_bidir, 0);
    chk("R1 down", rd_down, 0);
    chk("R1 pre", rd_pre, 0);
    chk("R1 count", count, 0);

    for (int i = 0; i < NV; i++) begin
      wr(0, 0, 1, 0, VEC[i][0]);
      wait_n(VEC[i][1]);
      chk("R2 prescale", count, VEC[i][2]);
    end

    wr(1, 0, 1, 0, 0);
    start_mask = 4'hF; evt_in = 4'hF; limit_in = 1;
    wait_n(5);
    chk("R4 count held", count, 0);
    chk("R4 stop unchanged", rd_stop, 0);
    chk("R4 no limit", limit_hit, 0);
    evt_in = 0; limit_in = 0;

    wr(1, 1, 0, 0, 0);
    chk("R5 stop forced 0", rd_stop, 0);
    chk("R5 halt", rd_halt, 1);
    evt_in = 4'hF;
    wait_n(20);
    chk("R6 halt sticky", rd_halt, 1);
    evt_in = 0;

    wr(0, 1, 1, 0, 0);
    chk("R6 halt released", rd_halt, 0);
    chk("R6 stopped", rd_stop, 1);
    wait_n(5);
    chk("R7 stop holds", count, 0);
    start_mask = 4'b0100; evt_in = 4'b0010;
    @(negedge clk);
    chk("R7 masked-out event", rd_stop, 1);
    evt_in = 4'b0100;
    @(negedge clk);
    evt_in = 0;
    chk("R7 start clears stop", rd_stop, 0);
    chk("R7 count before resume", count, 0);
    wait_n(3);
    chk("R7 resumed", count, 3);

    wait_n(2);
    chk("R3 pre-clear count", count, 5);
    wr(0, 0, 1, 0, 0);
    chk("R3 cleared", count, 0);
    chk("R3 clear reads 0", rd_clear, 0);

    wait_n(5);
    chk("R8 before limit", count, 5);
    limit_in = 1; #1;
    chk("R12 hit on tick", limit_hit, 1);
    @(negedge clk);
    limit_in = 0;
    chk("R8 restart", count, 0);
    chk("R8 down stays 0", rd_down, 0);
    @(negedge clk);
    chk("R8 counts after restart", count, 1);

    wr(0, 0, 1, 0, 3);
    limit_in = 1; hits = 0;
    for (int k = 0; k < 8; k++) begin
      #1;
      if (limit_hit) hits++;
      @(negedge clk);
    end
    limit_in = 0;
    chk("R12 hits only on ticks", hits, 2);
    chk("R8 held at 0", count, 0);
    wr(0, 1, 0, 0, 0);
    limit_in = 1; #1;
    chk("R12 no hit while stopped", limit_hit, 0);
    limit_in = 0;

    wr(0, 0, 1, 1, 0);
    wait_n(4);
    chk("R9 up count", count, 4);
    limit_in = 1;
    @(negedge clk);
    limit_in = 0;
    chk("R9 down set", rd_down, 1);
    chk("R9 decremented", count, 3);
    wait_n(2);
    chk("R11 down count", count, 1);
    @(negedge clk);
    chk("R11 at zero", count, 0);
    chk("R11 down cleared", rd_down, 0);
    @(negedge clk);
    chk("R11 up again", count, 1);
    wait_n(2);
    limit_in = 1;
    @(negedge clk);
    limit_in = 0;
    chk("R9 second reversal", count, 2);
    @(negedge clk);
    chk("R11 decrement", count, 1);
    limit_in = 1;
    @(negedge clk);
    limit_in = 0;
    chk("R10 down cleared", rd_down, 0);
    chk("R10 incremented", count, 2);
    @(negedge clk);
    chk("R10 counting up", count, 3);

    wr(0, 0, 1, 0, 0);
    wait_n(255);
    chk("R2 max value", count, 255);
    @(negedge clk);
    chk("R2 wrap", count, 0);

    done = 1;
    finish_run();
  end
endmodule